// File: doc/BRIEF.md
# Retriggerable Counter/Timer with Receive Idle Timeout

This block is a 16-bit down counter for a serial controller. Software loads a preload value through a byte-wide register port, then issues commands as read strobes at fixed addresses. A start command loads the count from the preload and makes it run. A stop command acknowledges the ready flag. Each pulse of `tick_en` moves a running count down by one.

In periodic mode the counter reloads itself at the end of every period and raises its ready flag each time. In idle-timeout mode the receive path pulses `rx_xfer` each time a character moves from the shift register into the holding register. Each pulse reloads the count and restarts it. If the pulses stop long enough for the count to run out, the ready flag is set once and the count rests at zero. Software can then drain a receive FIFO that never filled up. The interrupt line is the ready flag gated by a mask bit.

All pins carry plain control and status signals. Commands and `rx_xfer` are single-cycle events that are always accepted, with no back-pressure. No stream flows through the block, so there is no valid/ready handshake.

Top module: `ct_rx_timeout_timer`

## Requirements
- R1: After reset, `count` is 0 and both `ready` and `irq` are 0. The counter stays idle and ignores `tick_en` until the first start command or timeout retrigger.
- R2: A read strobe at address 0xE is a start command. On the next clock, `count` equals {upper byte at 0x6, lower byte at 0x7}. A start issued while the count is already running reloads the count at once.
- R3: While running, each cycle with `tick_en` high lowers `count` by one. Cycles without `tick_en` leave it unchanged.
- R4: In periodic mode (bit 0 of register 0x4 is 0), a tick taken at a count of 1 (or 0) reloads the preload and sets `ready`. Counting then continues without any further command.
- R5: A read strobe at address 0xF is a stop command. It clears `ready` but does not halt counting. If an expiry happens in the same cycle, the expiry wins.
- R6: In timeout mode (bit 0 of register 0x4 is 1), an `rx_xfer` pulse reloads the count from the preload and starts it. In periodic mode, `rx_xfer` has no effect on `count`.
- R7: In timeout mode, expiry sets `ready` once and `count` then holds at 0. Later ticks neither set `ready` again nor change `count` until the next `rx_xfer` or start command.
- R8: `irq` equals `ready` AND bit 3 of register 0x5. It follows either of them in the same cycle.
- R9: Writing the preload bytes does not disturb a count in progress. The new value takes effect at the next reload.
- R10: A start command or `rx_xfer` that arrives in the same cycle as a tick takes priority. The count loads the preload and does not decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (command addresses) |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| tick_en | input | 1 | Count enable pulse |
| rx_xfer | input | 1 | Received character moved to holding register |
| count | output | 16 | Current count value |
| ready | output | 1 | Counter-ready status flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench first checks that ticks before the first start leave the count at zero. A design that free-runs out of reset would already show a falling count there. It checks that periodic mode reloads and raises `ready` on the tick that reaches the end of the period, and that a stop command clears the flag while counting goes on. A design that halted on stop, or reloaded one tick late, would show the wrong count. In timeout mode it checks three things: an `rx_xfer` pulse restarts the window, expiry flags exactly once, and the count then parks at zero. A design that kept wrapping or flagged again would show a second `ready`. It also checks that a write to the preload mid-count is ignored until the next reload, and that a start arriving together with a tick loads the preload instead of decrementing.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int ADDR_MODE    = 4;
  localparam int ADDR_MASK    = 5;
  localparam int ADDR_PRE_HI  = 6;
  localparam int ADDR_PRE_LO  = 7;
  localparam int ADDR_START   = 14;
  localparam int ADDR_STOP    = 15;
  localparam int MASK_BIT     = 3;

  typedef struct packed {
    logic start;
    logic stop;
    logic xfer;
  } ct_cmd_t;
endpackage

// File: rtl/ct_bus_decode.sv
module ct_bus_decode
  import ct_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BYTE_W = 8,
  localparam int PRE_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              rx_xfer,
  output logic [PRE_W-1:0]  preload,
  output logic              mask_en,
  output logic              timeout_mode,
  output ct_cmd_t           cmd
);
  logic [BYTE_W-1:0] pre_hi_q, pre_lo_q;
  logic              mask_q, mode_q;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int target);
    return a == ADDR_W'(target);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_hi_q <= '0;
      pre_lo_q <= '0;
      mask_q   <= 1'b0;
      mode_q   <= 1'b0;
    end else if (bus_wr) begin
      if (hit(bus_addr, ADDR_PRE_HI)) pre_hi_q <= bus_wdata;
      if (hit(bus_addr, ADDR_PRE_LO)) pre_lo_q <= bus_wdata;
      if (hit(bus_addr, ADDR_MASK))   mask_q   <= bus_wdata[MASK_BIT];
      if (hit(bus_addr, ADDR_MODE))   mode_q   <= bus_wdata[0];
    end
  end

  always_comb begin
    cmd.start = bus_rd && !bus_wr && hit(bus_addr, ADDR_START);
    cmd.stop  = bus_rd && !bus_wr && hit(bus_addr, ADDR_STOP);
    cmd.xfer  = rx_xfer && mode_q;
  end

  assign preload      = {pre_hi_q, pre_lo_q};
  assign mask_en      = mask_q;
  assign timeout_mode = mode_q;

  // R6: a transfer pulse in periodic mode never yields a command
  a_r6_xfer_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_xfer && !timeout_mode) |-> !cmd.xfer);
endmodule

// File: rtl/ct_count_core.sv
module ct_count_core
  import ct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  ct_cmd_t          cmd,
  input  logic [CNT_W-1:0] preload,
  input  logic             timeout_mode,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;
  logic             running_q, armed_q;
  logic             reload_cmd, at_end;

  assign reload_cmd = cmd.start || cmd.xfer;
  assign at_end     = (count_q <= ONE);
  assign expire     = running_q && tick_en && !reload_cmd && at_end &&
                      (!timeout_mode || armed_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      running_q <= 1'b0;
      armed_q   <= 1'b0;
    end else if (reload_cmd) begin
      count_q   <= preload;
      running_q <= 1'b1;
      armed_q   <= 1'b1;
    end else if (running_q && tick_en) begin
      if (timeout_mode) begin
        if (armed_q) begin
          count_q <= at_end ? '0 : count_q - ONE;
          if (at_end) armed_q <= 1'b0;
        end
      end else begin
        count_q <= at_end ? preload : count_q - ONE;
      end
    end
  end

  assign count = count_q;

  // R1: idle counter does not move on a tick
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !reload_cmd) |=> $stable(count_q));
  // R2: a start loads the preload on the next edge
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.start |=> count_q == $past(preload));
  // R3: no tick and no reload keeps the count
  a_r3_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !reload_cmd) |=> $stable(count_q));
  // R7: a disarmed timeout count rests at zero
  a_r7_park_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_mode && !armed_q && running_q && !reload_cmd) |=> count_q == '0);
endmodule

// File: rtl/ct_status.sv
module ct_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic stop,
  input  logic mask_en,
  output logic ready,
  output logic irq
);
  logic ready_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ready_q <= 1'b0;
    else if (expire) ready_q <= 1'b1;
    else if (stop)   ready_q <= 1'b0;
  end

  assign ready = ready_q;
  assign irq   = ready_q && mask_en;

  // R5: stop without a concurrent expiry clears the flag
  a_r5_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !expire) |=> !ready);
  // R5: expiry wins over stop
  a_r5_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> ready);
endmodule

// File: rtl/ct_rx_timeout_timer.sv
module ct_rx_timeout_timer
  import ct_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              tick_en,
  input  logic              rx_xfer,
  output logic [CNT_W-1:0]  count,
  output logic              ready,
  output logic              irq
);
  logic [CNT_W-1:0] preload;
  logic             mask_en, timeout_mode, expire;
  ct_cmd_t          cmd;

  ct_bus_decode #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_decode (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .rx_xfer,
    .preload, .mask_en, .timeout_mode, .cmd
  );

  ct_count_core #(.CNT_W(CNT_W)) u_core (
    .clk, .rst_n, .tick_en, .cmd, .preload, .timeout_mode, .count, .expire
  );

  ct_status u_status (
    .clk, .rst_n, .expire, .stop(cmd.stop), .mask_en, .ready, .irq
  );

  // R8: interrupt is the masked ready flag
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (ready && mask_en));
endmodule

// File: tb/ct_rx_timeout_timer_bench.sv
module ct_rx_timeout_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, tick_en = 1'b0, rx_xfer = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] count;
  logic        ready, irq;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ct_rx_timeout_timer u_ct_rx_timeout_timer (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata,
    .tick_en, .rx_xfer, .count, .ready, .irq
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic xfer();
    @(negedge clk); rx_xfer = 1'b1;
    @(negedge clk); rx_xfer = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", count, 16'h0);
    chk("R1 ready", {15'b0, ready}, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    wr(4'h7, 8'h04);
    for (int i = 0; i < 3; i++) tick();
    chk("R1 idle before start", count, 16'h0);
  endtask

  task automatic t_periodic();
    wr(4'h6, 8'h01); wr(4'h7, 8'h02);
    rd(4'hE);
    chk("R2 upper byte load", count, 16'h0102);
    wr(4'h6, 8'h00); wr(4'h7, 8'h03); wr(4'h5, 8'h08);
    chk("R9 write keeps count", count, 16'h0102);
    rd(4'hE);
    chk("R2 restart", count, 16'h0003);
    tick(); chk("R3 dec", count, 16'h0002);
    @(negedge clk); chk("R3 no tick", count, 16'h0002);
    tick(); chk("R3 dec", count, 16'h0001);
    chk("R4 not yet", {15'b0, ready}, 16'h0);
    tick();
    chk("R4 reload", count, 16'h0003);
    chk("R4 ready", {15'b0, ready}, 16'h1);
    chk("R8 irq on", {15'b0, irq}, 16'h1);
    tick(); chk("R4 continuous", count, 16'h0002);
    wr(4'h5, 8'h00);
    chk("R8 irq masked", {15'b0, irq}, 16'h0);
    rd(4'hF);
    chk("R5 stop clears", {15'b0, ready}, 16'h0);
    tick(); chk("R5 still counting", count, 16'h0001);
  endtask

  task automatic t_priority();
    wr(4'h7, 8'h05);
    chk("R9 pending preload", count, 16'h0001);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 4'hE; tick_en = 1'b1;
    @(negedge clk); bus_rd = 1'b0; tick_en = 1'b0;
    chk("R10 start over tick", count, 16'h0005);
    chk("R10 no expiry", {15'b0, ready}, 16'h0);
  endtask

  task automatic t_timeout();
    wr(4'h4, 8'h01); wr(4'h5, 8'h08);
    wr(4'h7, 8'h02);
    xfer(); chk("R6 xfer loads", count, 16'h0002);
    tick(); chk("R6 dec", count, 16'h0001);
    xfer(); chk("R6 retrigger", count, 16'h0002);
    @(negedge clk); rx_xfer = 1'b1; tick_en = 1'b1;
    @(negedge clk); rx_xfer = 1'b0; tick_en = 1'b0;
    chk("R10 xfer over tick", count, 16'h0002);
    tick(); tick();
    chk("R7 expiry zero", count, 16'h0000);
    chk("R7 ready", {15'b0, ready}, 16'h1);
    chk("R8 irq", {15'b0, irq}, 16'h1);
    rd(4'hF);
    chk("R5 stop in timeout", {15'b0, ready}, 16'h0);
    tick(); tick();
    chk("R7 parked", count, 16'h0000);
    chk("R7 once only", {15'b0, ready}, 16'h0);
    xfer(); chk("R6 next burst", count, 16'h0002);
    wr(4'h4, 8'h00);
    tick(); chk("R4 back to periodic", count, 16'h0001);
    xfer(); chk("R6 xfer ignored periodic", count, 16'h0001);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_periodic();
    t_priority();
    t_timeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule